// File: doc/BRIEF.md
# SPI Idle-Fill and Escape Physical Layer

This block is the lowest layer of a serial slave port. The host drives the SPI clock in mode 1: the clock rests low, each side changes its data on the rising edge and samples it on the falling edge. Bytes travel most significant bit first. The block takes the clock, select and data lines into its own system clock through synchronisers, assembles received bytes and cleans them. Two byte values are reserved on the wire. 0x4A is a filler and is thrown away wherever it shows up. 0x4D marks the next byte as flipped with 0x20. The upper packet layer therefore sees only its own bytes, through a valid/ready stream.

In the other direction, the packet layer offers response bytes through a second valid/ready stream. The block holds one of them. Any byte that collides with a reserved value is sent as 0x4D followed by the byte XOR 0x20. When nothing is queued, every outgoing slot carries the filler 0x4A. While a request is still arriving, the packet layer offers nothing, so the host only sees filler until the response starts.

Top module: `spi_idle_phy`

## Requirements
- R1: After reset, spi_miso is 0, rx_valid and rx_esc_err are 0, and tx_ready is 1.
- R2: In mode 1, spi_mosi is captured on each falling spi_sclk edge and spi_miso changes after each rising edge. Both directions carry bit 7 first, eight bits to a byte.
- R3: A received 0x4A is dropped in any position and produces no output byte.
- R4: A received 0x4D produces no output. The next received byte other than 0x4A is delivered XOR 0x20. Any 0x4A bytes between the two are dropped, and the escape stays pending across them.
- R5: A 0x4D that arrives while an escape is pending raises rx_esc_err for exactly one clock and is dropped. The pending escape is cleared, so the following byte is delivered unmodified.
- R6: If no response byte is queued when a new outgoing byte starts, the block shifts out 0x4A.
- R7: A queued response byte equal to 0x4A or 0x4D goes out as 0x4D followed by the byte XOR 0x20. Other bytes go out verbatim, and the order of response bytes is kept.
- R8: While tx_valid stays high, a new byte is accepted in the same clock that the held byte is handed to the shifter. The outgoing stream then has no filler gaps between response bytes.
- R9: rx_data stays stable while rx_valid is 1 and rx_ready is 0. A newly decoded byte that arrives before the held one is accepted replaces it.
- R10: A high spi_cs_n clears both bit counters, so a partially shifted byte is discarded and the next selected transfer starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rx_valid | output | 1 | Cleaned received byte available |
| rx_ready | input | 1 | Packet layer accepts rx_data |
| rx_data | output | 8 | Cleaned received byte |
| rx_esc_err | output | 1 | One-cycle pulse on a doubled escape |
| tx_valid | input | 1 | Packet layer offers a response byte |
| tx_ready | output | 1 | Response byte holder can accept |
| tx_data | input | 8 | Response byte |

## Verification
The interesting collision is on the transmit side. In one clock, the shifter takes the held response byte, or the first half of its escape pair, and the packet layer refills the holder. The bench keeps tx_valid high from a queue, so this refill happens on every byte of a full-duplex transfer. At the same time the host sends bytes mixed with filler and escapes. The reference model encodes the queued bytes on its own and compares every byte captured from spi_miso against that encoding. A lost, doubled or filler-separated response byte shows up as a mismatch. The bench also checks, on every clock, that each handshaken rx_data equals the next byte decoded by the model.

// File: rtl/spi_phy_pkg.sv
package spi_phy_pkg;
  localparam int          BYTE_W    = 8;
  localparam logic [7:0]  FILL_CODE = 8'h4A;
  localparam logic [7:0]  MARK_CODE = 8'h4D;
  localparam logic [7:0]  FLIP_MASK = 8'h20;
endpackage

// File: rtl/spi_phy_shifter.sv
module spi_phy_shifter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         mosi_i,
  output logic         miso_o,
  output logic         rx_stb_o,
  output logic [W-1:0] rx_byte_o,
  input  logic [W-1:0] tx_byte_i,
  output logic         take_o
);
  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // synchroniser chain, bit order {sclk, cs_n, mosi}
  logic [2:0] sy [SYNC_STAGES];
  logic       sclk_d;
  logic       s_sclk, s_cs, s_mosi, rise, fall;
  logic [W-1:0]  rx_sh, tx_sh;
  logic [CW-1:0] rx_cnt, tx_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= 3'b010;
    end else begin
      sy[0] <= {sclk_i, cs_n_i, mosi_i};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
    end
  end

  always_comb begin
    s_sclk = sy[SYNC_STAGES-1][2];
    s_cs   = sy[SYNC_STAGES-1][1];
    s_mosi = sy[SYNC_STAGES-1][0];
    rise   = s_sclk && !sclk_d && !s_cs;
    fall   = !s_sclk && sclk_d && !s_cs;
    take_o = rise && (tx_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_cnt    <= '0;
      tx_cnt    <= '0;
      miso_o    <= 1'b0;
      rx_stb_o  <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      sclk_d   <= s_sclk;
      rx_stb_o <= 1'b0;
      if (s_cs) begin
        rx_cnt <= '0;
        tx_cnt <= '0;
      end else begin
        if (fall) begin
          rx_sh  <= {rx_sh[W-2:0], s_mosi};
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == LAST) begin
            rx_stb_o  <= 1'b1;
            rx_byte_o <= {rx_sh[W-2:0], s_mosi};
            rx_cnt    <= '0;
          end
        end
        if (rise) begin
          if (tx_cnt == '0) begin
            miso_o <= tx_byte_i[W-1];
            tx_sh  <= {tx_byte_i[W-2:0], 1'b0};
          end else begin
            miso_o <= tx_sh[W-1];
            tx_sh  <= {tx_sh[W-2:0], 1'b0};
          end
          tx_cnt <= (tx_cnt == LAST) ? '0 : tx_cnt + 1'b1;
        end
      end
    end
  end

  // R10: deselect returns both counters to bit 7 position
  a_r10_cs_clears: assert property (@(posedge clk) disable iff (rst)
    s_cs |=> (rx_cnt == '0 && tx_cnt == '0))
    else $error("a_r10_cs_clears");
endmodule

// File: rtl/spi_phy_rx_clean.sv
module spi_phy_rx_clean
  import spi_phy_pkg::*;
#(
  parameter int          W    = BYTE_W,
  parameter logic [W-1:0] FILL = FILL_CODE,
  parameter logic [W-1:0] MARK = MARK_CODE,
  parameter logic [W-1:0] FLIP = FLIP_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_stb,
  input  logic [W-1:0] in_byte,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         err_o
);
  logic         esc_q;
  logic         emit;
  logic [W-1:0] nb;
  logic         live;

  always_comb begin
    live = in_stb && (in_byte != FILL);
    emit = 1'b0;
    nb   = in_byte;
    if (live) begin
      if (esc_q) begin
        if (in_byte != MARK) begin
          emit = 1'b1;
          nb   = in_byte ^ FLIP;
        end
      end else if (in_byte != MARK) begin
        emit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_q     <= 1'b0;
      err_o     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      err_o <= 1'b0;
      if (live) begin
        if (esc_q) begin
          esc_q <= 1'b0;
          if (in_byte == MARK) err_o <= 1'b1;
        end else if (in_byte == MARK) begin
          esc_q <= 1'b1;
        end
      end
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= nb;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5: error is a single-cycle pulse
  a_r5_err_single: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o) else $error("a_r5_err_single");
  // R9: unaccepted byte holds unless replaced
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !emit) |=> (out_valid && $stable(out_data)))
    else $error("a_r9_hold");
  // R3: a filler byte never alters the output byte
  a_r3_fill_silent: assert property (@(posedge clk) disable iff (rst)
    (in_stb && in_byte == FILL) |=> $stable(out_data))
    else $error("a_r3_fill_silent");
endmodule

// File: rtl/spi_phy_tx_stuff.sv
module spi_phy_tx_stuff
  import spi_phy_pkg::*;
#(
  parameter int          W    = BYTE_W,
  parameter logic [W-1:0] FILL = FILL_CODE,
  parameter logic [W-1:0] MARK = MARK_CODE,
  parameter logic [W-1:0] FLIP = FLIP_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  output logic         up_ready,
  input  logic         take,
  output logic [W-1:0] out_byte
);
  logic         hold_v, pend_v;
  logic [W-1:0] hold_q, pend_q;
  logic         special, use_hold;

  always_comb begin
    special  = (hold_q == FILL) || (hold_q == MARK);
    use_hold = take && !pend_v && hold_v;
    up_ready = !hold_v || use_hold;
    if (pend_v)      out_byte = pend_q;
    else if (hold_v) out_byte = special ? MARK : hold_q;
    else             out_byte = FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_q <= '0;
      pend_v <= 1'b0;
      pend_q <= '0;
    end else begin
      if (take && pend_v) pend_v <= 1'b0;
      if (use_hold) begin
        hold_v <= 1'b0;
        if (special) begin
          pend_v <= 1'b1;
          pend_q <= hold_q ^ FLIP;
        end
      end
      if (up_valid && up_ready) begin
        hold_v <= 1'b1;
        hold_q <= up_data;
      end
    end
  end

  // R7: second half of an escape pair leaves on the next take
  a_r7_pend_drains: assert property (@(posedge clk) disable iff (rst)
    (take && pend_v) |=> !pend_v) else $error("a_r7_pend_drains");
  // R8: held byte is never lost before the shifter takes it
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !take) |=> (hold_v && $stable(hold_q)))
    else $error("a_r8_hold_kept");
endmodule

// File: rtl/spi_idle_phy.sv
module spi_idle_phy
  import spi_phy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_esc_err,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data
);
  logic              raw_stb, take;
  logic [BYTE_W-1:0] raw_byte, next_tx;

  spi_phy_shifter #(.W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .miso_o(spi_miso),
    .rx_stb_o(raw_stb), .rx_byte_o(raw_byte),
    .tx_byte_i(next_tx), .take_o(take)
  );

  spi_phy_rx_clean u_rx (
    .clk(clk), .rst(rst),
    .in_stb(raw_stb), .in_byte(raw_byte),
    .out_ready(rx_ready), .out_valid(rx_valid), .out_data(rx_data),
    .err_o(rx_esc_err)
  );

  spi_phy_tx_stuff u_tx (
    .clk(clk), .rst(rst),
    .up_valid(tx_valid), .up_data(tx_data), .up_ready(tx_ready),
    .take(take), .out_byte(next_tx)
  );
endmodule

// File: tb/test_spi_idle_phy.sv
module test_spi_idle_phy;
  typedef logic [7:0] bq_t[$];
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic rx_valid, rx_esc_err, tx_ready;
  logic rx_ready = 1'b1;
  logic tx_valid = 1'b0;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;

  int checks = 0, fails = 0;
  int err_seen = 0, err_exp = 0;
  bit done = 1'b0, rx_hold = 1'b0, hold_mode = 1'b0, m_esc = 1'b0, tx_fire = 1'b0;
  logic [7:0] exp_rx[$];
  logic [7:0] txq[$];

  always #2.5 clk = ~clk;

  spi_idle_phy i_spi_idle_phy (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_esc_err(rx_esc_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural decoder of the host stream
  task automatic model_rx(input logic [7:0] b);
    if (b == 8'h4A) return;
    if (m_esc) begin
      m_esc = 1'b0;
      if (b == 8'h4D) err_exp++;
      else begin
        if (hold_mode) exp_rx.delete();
        exp_rx.push_back(b ^ 8'h20);
      end
    end else if (b == 8'h4D) m_esc = 1'b1;
    else begin
      if (hold_mode) exp_rx.delete();
      exp_rx.push_back(b);
    end
  endtask

  // per-clock comparison and upstream feeder
  always @(negedge clk) begin
    if (tx_fire) void'(txq.pop_front());
    tx_valid = (txq.size() > 0);
    tx_data  = tx_valid ? txq[0] : 8'h00;
    tx_fire  = tx_valid && tx_ready;
    rx_ready = !rx_hold;
    if (rx_esc_err) err_seen++;
    if (!rst && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0)
        chk(1'b0, "R3", "unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R4", "rx byte", rx_data, e);
      end
    end
  end

  task automatic spi_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk);
      spi_sclk = 1'b1;
      spi_mosi = b[i];
      repeat (HP) @(negedge clk);
      spi_sclk = 1'b0;
      r = {r[6:0], spi_miso};
      repeat (HP - 1) @(negedge clk);
    end
  endtask

  task automatic xfer(input bq_t mo, input bq_t tb, input string req);
    logic [7:0] expm[$];
    logic [7:0] got[$];
    logic [7:0] r;
    foreach (tb[i]) begin
      if (tb[i] == 8'h4A || tb[i] == 8'h4D) begin
        expm.push_back(8'h4D);
        expm.push_back(tb[i] ^ 8'h20);
      end else expm.push_back(tb[i]);
      txq.push_back(tb[i]);
    end
    foreach (mo[i]) model_rx(mo[i]);
    repeat (6) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (mo[i]) begin
      spi_byte(mo[i], 8, r);
      got.push_back(r);
    end
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (16) @(negedge clk);
    foreach (got[i]) begin
      logic [7:0] e;
      e = (i < expm.size()) ? expm[i] : 8'h4A;
      chk(got[i] == e, req, $sformatf("miso byte %0d", i), got[i], e);
    end
    chk(exp_rx.size() == 0 || hold_mode, req, "rx bytes outstanding", exp_rx.size(), 0);
    chk(err_seen == err_exp, "R5", "escape error count", err_seen, err_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_miso == 1'b0, "R1", "miso after reset", spi_miso, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    chk(rx_esc_err == 1'b0, "R1", "err after reset", rx_esc_err, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);

    // R2 R6: plain bytes in, nothing queued out -> filler
    xfer('{8'h11, 8'h22, 8'hA5}, '{}, "R6");
    // R3: filler scattered in the request
    xfer('{8'h4A, 8'h11, 8'h4A, 8'h4A, 8'h22, 8'h4A}, '{}, "R3");
    // R4: escapes, with filler between an escape and its byte
    xfer('{8'h4D, 8'h6A, 8'h4D, 8'h6D, 8'h4D, 8'h4A, 8'h6A, 8'h4D, 8'h5B, 8'h33}, '{}, "R4");
    // R5: doubled escape
    xfer('{8'h4D, 8'h4D, 8'h55, 8'h66}, '{}, "R5");
    // R7 R8: full duplex, response with reserved values, continuous offer
    xfer('{8'h12, 8'h4A, 8'h34, 8'h4A, 8'h4A, 8'h56, 8'h4A, 8'h4A},
         '{8'h01, 8'h4A, 8'h4D, 8'h7F, 8'h4A}, "R7");
    xfer('{8'h4A, 8'h4A, 8'h4A, 8'h4A}, '{8'hC3, 8'h3C, 8'h99, 8'h00}, "R8");

    // R9: held byte replaced by a newer one
    @(posedge clk); rx_hold = 1'b1; hold_mode = 1'b1;
    xfer('{8'h11, 8'h22}, '{}, "R9");
    @(negedge clk);
    chk(rx_valid == 1'b1, "R9", "valid while held", rx_valid, 1);
    chk(rx_data == 8'h22, "R9", "newest byte kept", rx_data, 8'h22);
    @(posedge clk); rx_hold = 1'b0; hold_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_rx.size() == 0, "R9", "held byte drained", exp_rx.size(), 0);

    // R10: partial byte dropped by deselect
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    spi_byte(8'hF0, 4, r);
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (16) @(negedge clk);
    chk(rx_valid == 1'b0, "R10", "no byte from partial", rx_valid, 0);
    xfer('{8'h5A}, '{}, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule